// File: doc/BRIEF.md
# Halfword-Packed Colour Palette

This block is a 256-entry colour lookup table. Each entry holds a 15-bit colour and one spare bit. The entries are packed two to a 32-bit word, so the whole table takes 128 words. Software programs the table through a word-addressed register port with byte strobes. A strobe pair that covers one halfword updates a single entry without disturbing its neighbour.

On the display side, the pixel pipeline presents an 8-bit index together with a valid flag in every cycle. Exactly one cycle later the block returns the 24-bit colour, with each 5-bit component widened to 8 bits. A byte-order input selects which halfword of a word holds the even entry. The pixel lookup honours this selection, and software that writes the table must lay out its data to match.

Top module: `pal_halfword_lut`

## Requirements
- R1: The table has 256 entries in 128 words, and entry n lives in word n/2. A register read (reg_en_i=1, reg_we_i=0) of word offset a returns that 32-bit word on reg_rdata_o in the cycle after the request.
- R2: When be_mode_i=0, an even index selects bits 15:0 of its word and an odd index selects bits 31:16.
- R3: When be_mode_i=1, the index is XORed with 1 before the halfword is chosen. An even index therefore selects bits 31:16 and an odd index selects bits 15:0. be_mode_i is sampled in the same cycle as the index.
- R4: Within an entry, bits 4:0 hold red, bits 9:5 hold green and bits 14:10 hold blue. pix_rgb_o carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R5: pix_valid_o is high exactly one cycle after pix_valid_i is high. In that cycle pix_rgb_o holds the colour of the index that was presented.
- R6: Each 5-bit component c widens to the 8-bit value {c, c[4:2]}.
- R7: A write (reg_en_i=1, reg_we_i=1) updates only the bytes whose reg_be_i bit is set. Bit k of reg_be_i covers data bits 8k+7:8k. A halfword write leaves the other entry of the word unchanged.
- R8: Bit 15 of an entry reads back as written and has no effect on pix_rgb_o.
- R9: A pixel lookup in the same cycle as a write to the same word returns the value the word held before the write.
- R10: While reset is asserted and after it is released, pix_valid_o and reg_rdata_o are 0 until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| be_mode_i | input | 1 | 1 selects big-endian halfword placement |
| reg_en_i | input | 1 | Register port access strobe |
| reg_we_i | input | 1 | 1 selects write, 0 selects read |
| reg_addr_i | input | 7 | Word offset within the table |
| reg_wdata_i | input | 32 | Write data |
| reg_be_i | input | 4 | Byte strobes for writes |
| reg_rdata_o | output | 32 | Read data, one cycle after the read request |
| pix_valid_i | input | 1 | Pixel index valid |
| pix_idx_i | input | 8 | Pixel palette index |
| pix_valid_o | output | 1 | Colour valid |
| pix_rgb_o | output | 24 | Expanded colour: red 23:16, green 15:8, blue 7:0 |

## Verification
The bench builds the block with its default parameters: 256 entries, 5-bit components and 8-bit output channels. With these values the full index space is reachable, including word 0, word 127 and both lanes of each word. The bench fills every word and then sweeps indices in both byte-order modes. It places halfword writes, a write of the spare bit, and a write that lands in the same cycle as a lookup of the same word. Together these bring every lane-selection and read-before-write case within reach.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int PAL_ENTRIES = 256;
  localparam int PAL_COMP_W  = 5;
  localparam int PAL_CHAN_W  = 8;
  localparam int PAL_NCOMP   = 3;
  localparam int PAL_ENTRY_W = 16;
  localparam int PAL_WORD_W  = 2 * PAL_ENTRY_W;
endpackage

// File: rtl/pal_word_store.sv
module pal_word_store #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NBYTES-1:0] wr_be_i,
  input  logic              cpu_rd_en_i,
  input  logic [ADDR_W-1:0] cpu_rd_addr_i,
  output logic [DATA_W-1:0] cpu_rd_data_o,
  input  logic              pix_rd_en_i,
  input  logic [ADDR_W-1:0] pix_rd_addr_i,
  output logic [DATA_W-1:0] pix_rd_data_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  // Byte-lane write; untouched lanes keep their contents
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_be_i[b]) mem_q[wr_addr_i][8*b +: 8] <= wr_data_i[8*b +: 8];
      end
    end
  end

  // Reads sample the array before this edge's write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rd_data_o <= '0;
      pix_rd_data_o <= '0;
    end else begin
      if (cpu_rd_en_i) cpu_rd_data_o <= mem_q[cpu_rd_addr_i];
      if (pix_rd_en_i) pix_rd_data_o <= mem_q[pix_rd_addr_i];
    end
  end
endmodule

// File: rtl/pal_lane_pick.sv
module pal_lane_pick #(
  parameter int ENTRY_W = 16,
  localparam int WORD_W = 2 * ENTRY_W
) (
  input  logic [WORD_W-1:0]  word_i,
  input  logic               lane_i,
  output logic [ENTRY_W-1:0] entry_o
);
  always_comb entry_o = lane_i ? word_i[WORD_W-1:ENTRY_W] : word_i[ENTRY_W-1:0];
endmodule

// File: rtl/pal_comp_expand.sv
module pal_comp_expand #(
  parameter int IN_W  = 5,
  parameter int OUT_W = 8,
  localparam int PAD_W = OUT_W - IN_W
) (
  input  logic [IN_W-1:0]  comp_i,
  output logic [OUT_W-1:0] chan_o
);
  // Replicate top bits so that full scale maps to full scale
  always_comb chan_o = {comp_i, comp_i[IN_W-1 -: PAD_W]};
endmodule

// File: rtl/pal_halfword_lut.sv
module pal_halfword_lut
  import pal_pkg::*;
#(
  parameter int ENTRIES = PAL_ENTRIES,
  parameter int COMP_W  = PAL_COMP_W,
  parameter int CHAN_W  = PAL_CHAN_W,
  localparam int NCOMP  = PAL_NCOMP,
  localparam int ENTRY_W = PAL_ENTRY_W,
  localparam int WORD_W  = 2 * ENTRY_W,
  localparam int WORDS   = ENTRIES / 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ADDR_W  = $clog2(WORDS),
  localparam int RGB_W   = NCOMP * CHAN_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                be_mode_i,
  input  logic                reg_en_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [WORD_W-1:0]   reg_wdata_i,
  input  logic [WORD_W/8-1:0] reg_be_i,
  output logic [WORD_W-1:0]   reg_rdata_o,
  input  logic                pix_valid_i,
  input  logic [IDX_W-1:0]    pix_idx_i,
  output logic                pix_valid_o,
  output logic [RGB_W-1:0]    pix_rgb_o
);
  logic [WORD_W-1:0]  pix_word;
  logic [ENTRY_W-1:0] pix_entry;
  logic               lane_q;
  logic               valid_q;

  pal_word_store #(.WORDS(WORDS), .DATA_W(WORD_W)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (reg_en_i & reg_we_i),
    .wr_addr_i     (reg_addr_i),
    .wr_data_i     (reg_wdata_i),
    .wr_be_i       (reg_be_i),
    .cpu_rd_en_i   (reg_en_i & ~reg_we_i),
    .cpu_rd_addr_i (reg_addr_i),
    .cpu_rd_data_o (reg_rdata_o),
    .pix_rd_en_i   (pix_valid_i),
    .pix_rd_addr_i (pix_idx_i[IDX_W-1:1]),
    .pix_rd_data_o (pix_word)
  );

  // Halfword lane: index LSB, flipped in big-endian byte order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= pix_valid_i;
      if (pix_valid_i) lane_q <= pix_idx_i[0] ^ be_mode_i;
    end
  end

  pal_lane_pick #(.ENTRY_W(ENTRY_W)) u_lane (
    .word_i  (pix_word),
    .lane_i  (lane_q),
    .entry_o (pix_entry)
  );

  // Component k sits at entry bits k*COMP_W; red (k=0) goes to the top channel
  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    pal_comp_expand #(.IN_W(COMP_W), .OUT_W(CHAN_W)) u_exp (
      .comp_i (pix_entry[k*COMP_W +: COMP_W]),
      .chan_o (pix_rgb_o[(NCOMP-1-k)*CHAN_W +: CHAN_W])
    );
  end

  assign pix_valid_o = valid_q;
endmodule

// File: rtl/pal_halfword_lut_chk.sv
module pal_halfword_lut_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        be_mode_i,
  input logic        reg_en_i,
  input logic        reg_we_i,
  input logic [6:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic [3:0]  reg_be_i,
  input logic [31:0] reg_rdata_o,
  input logic        pix_valid_i,
  input logic [7:0]  pix_idx_i,
  input logic        pix_valid_o,
  input logic [23:0] pix_rgb_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_valid_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd0) |-> (pix_valid_o == $past(pix_valid_i)));

  p_red_widen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_rgb_o[18:16] == pix_rgb_o[23:21]));

  p_green_widen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_rgb_o[10:8] == pix_rgb_o[15:13]));

  p_blue_widen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (pix_rgb_o[2:0] == pix_rgb_o[7:5]));

  // A full-word write followed by a read of the same word returns that data
  p_write_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && reg_en_i && !reg_we_i &&
     $past(reg_en_i && reg_we_i && (reg_be_i == 4'hF)) &&
     ($past(reg_addr_i) == reg_addr_i))
    |=> (reg_rdata_o == $past(reg_wdata_i, 2)));
endmodule

bind pal_halfword_lut pal_halfword_lut_chk u_chk (.*);

// File: tb/pal_halfword_lut_bench.sv
module pal_halfword_lut_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        be_mode_i = 1'b0;
  logic        reg_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [6:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [3:0]  reg_be_i = '0;
  logic [31:0] reg_rdata_o;
  logic        pix_valid_i = 1'b0;
  logic [7:0]  pix_idx_i = '0;
  logic        pix_valid_o;
  logic [23:0] pix_rgb_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] mdl [128];
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #5 clk_i = ~clk_i;

  pal_halfword_lut u_pal_halfword_lut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] widen(input logic [4:0] c);
    return 8'((int'(c) * 8) + (int'(c) / 4));
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic [7:0] idx, input logic be);
    logic [15:0] e;
    e = ((idx[0] ^ be) == 1'b1) ? w[31:16] : w[15:0];
    return {widen(e[4:0]), widen(e[9:5]), widen(e[14:10])};
  endfunction

  task automatic pix(input logic [7:0] idx, input logic be, input string tag);
    pix_valid_i = 1'b1;
    pix_idx_i   = idx;
    be_mode_i   = be;
    exp_q.push_back(exp_rgb(mdl[idx[7:1]], idx, be));
    tag_q.push_back(tag);
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_be_i = be;
    @(negedge clk_i);
    for (int b = 0; b < 4; b++) if (be[b]) mdl[a][8*b +: 8] = d[8*b +: 8];
    reg_en_i = 1'b0; reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input string tag);
    reg_en_i = 1'b1; reg_we_i = 1'b0; reg_addr_i = a;
    @(negedge clk_i);
    reg_en_i = 1'b0;
    chk(reg_rdata_o == mdl[a], tag, reg_rdata_o, mdl[a]);
  endtask

  // Scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done && pix_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected valid", 32'(pix_rgb_o), 32'h0);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pix_rgb_o == e, t, 32'(pix_rgb_o), 32'(e));
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(pix_valid_o == 1'b0, "R10 valid in reset", 32'(pix_valid_o), 0);
    chk(reg_rdata_o == 32'h0, "R10 rdata in reset", reg_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pix_valid_o == 1'b0, "R10 valid after reset", 32'(pix_valid_o), 0);
    chk(reg_rdata_o == 32'h0, "R10 rdata after reset", reg_rdata_o, 0);

    // R1: fill every word
    for (int i = 0; i < 128; i++) wr(7'(i), (32'(i) * 32'h0137_0B1F) ^ 32'hA5C3_5A3C, 4'hF);
    rd(7'd0, "R1 word 0");
    rd(7'd127, "R1 word 127");
    rd(7'd64, "R1 word 64");

    // R2 R4 R6: little-endian lookups, back to back
    pix(8'd0, 1'b0, "R2 even idx 0");
    pix(8'd1, 1'b0, "R2 odd idx 1");
    pix(8'd254, 1'b0, "R2 even idx 254");
    pix(8'd255, 1'b0, "R2 odd idx 255");
    for (int i = 0; i < 40; i++) pix(8'((i * 37 + 11) % 256), 1'b0, "R4 LE sweep");

    // R3: big-endian lookups
    pix(8'd0, 1'b1, "R3 even idx 0");
    pix(8'd1, 1'b1, "R3 odd idx 1");
    pix(8'd255, 1'b1, "R3 odd idx 255");
    for (int i = 0; i < 40; i++) pix(8'((i * 53 + 7) % 256), 1'b1, "R3 BE sweep");
    pix(8'd2, 1'b0, "R3 mode flip back");

    // R6: full-scale and mid components
    wr(7'd3, 32'h7FFF_4210, 4'hF);
    pix(8'd6, 1'b0, "R6 entry 0x4210");
    pix(8'd7, 1'b0, "R6 entry 0x7fff");

    // R7: halfword writes keep the neighbour
    wr(7'd5, 32'h1234_5678, 4'hF);
    wr(7'd5, 32'hFFFF_0ABC, 4'b0011);
    rd(7'd5, "R7 low half write");
    pix(8'd11, 1'b0, "R7 odd neighbour kept");
    pix(8'd10, 1'b0, "R7 even updated");
    wr(7'd5, 32'h6543_FFFF, 4'b1100);
    rd(7'd5, "R7 high half write");
    wr(7'd5, 32'hAAAA_AA99, 4'b0001);
    rd(7'd5, "R7 single byte");

    // R8: spare bit reads back, colour ignores it
    wr(7'd6, 32'h7FFF_8000, 4'hF);
    rd(7'd6, "R8 bit15 readback");
    pix(8'd12, 1'b0, "R8 bit15 no colour");
    wr(7'd6, 32'hFFFF_8000, 4'hF);
    pix(8'd13, 1'b0, "R8 bit15 set full scale");

    // R9: write and lookup of same word in one cycle
    wr(7'd7, 32'h0000_0000, 4'hF);
    reg_en_i = 1'b1; reg_we_i = 1'b1; reg_addr_i = 7'd7; reg_wdata_i = 32'h7C1F_03E0; reg_be_i = 4'hF;
    pix(8'd14, 1'b0, "R9 old value on collision");
    reg_en_i = 1'b0; reg_we_i = 1'b0;
    mdl[7] = 32'h7C1F_03E0;
    pix(8'd14, 1'b0, "R9 new value after");
    pix(8'd15, 1'b0, "R9 new odd value after");

    // R5: idle gap yields no valid
    @(negedge clk_i);
    @(negedge clk_i);
    chk(pix_valid_o == 1'b0, "R5 idle no valid", 32'(pix_valid_o), 0);
    chk(exp_q.size() == 0, "R5 all results seen", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule